// File: doc/BRIEF.md
# Multi-Channel Output Compare Timer with Master Override

A free-running 16-bit up-counter advances once per prescaler tick pulse and feeds eight compare channels that drive an 8-bit timer output port. Channels 0 to 6 each own one port bit. When the counter steps onto a channel's compare value, that channel applies a configured action to its bit: toggle, clear, set, or leave it alone.

Channel 7 is a master channel. When it matches, every port bit selected by a mask register is loaded from the same-numbered bit of a master data register. For the selected bits this load beats any per-channel action that matches in the same cycle.

All registers sit on a simple word-wide register bus. Each write and each read moves a full 16-bit word in one cycle, so the counter is never seen half-updated. A mode input keeps the counter write-protected during normal operation.

Top module: `oc_master_timer`

## Requirements
- R1: On a cycle with `tick` high and no accepted counter write, the counter increases by one and wraps from 0xFFFF to 0x0000. On other cycles without an accepted write it holds its value.
- R2: A write to the counter (address 8) is accepted only while `mode_n` is low. While `mode_n` is high the write is ignored and the counter keeps counting.
- R3: An accepted counter write loads the full 16-bit `wdata` in one cycle and takes priority over a tick in that cycle. Loading the counter never triggers a compare.
- R4: A channel matches only on a tick cycle in which the incremented counter value equals its compare register. On any cycle without a tick, `port_out` does not change.
- R5: For channels 0 to 6, the 2-bit action field at register 9, bits [2n+1:2n], selects the effect on port bit n when channel n matches: 00 no change, 01 toggle, 10 clear, 11 set.
- R6: When channel 7 matches, every port bit whose bit in the mask register (address 10) is 1 takes the value of the same bit of the master data register (address 11).
- R7: When channel 7 and channel n match in the same cycle and mask bit n is 1, port bit n takes the master data bit and the action of channel n is discarded.
- R8: Port bits whose mask bit is 0 are never changed by channel 7. Port bit 7 is changed only by channel 7.
- R9: Registers are word-wide and readable at any time on `rdata`, combinationally from `addr`. Addresses 0 to 7 hold the compare values of channels 0 to 7, address 8 the counter, address 9 the actions, address 10 the mask, and address 11 the master data. Other addresses read as zero.
- R10: After reset, the counter, compare registers, actions, mask, master data and `port_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick pulse; the counter advances on each one |
| mode_n | input | 1 | Low selects special mode, which allows counter writes |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| port_out | output | 8 | Timer output port |

## Verification
The hardest case to reach from the ports is the master channel and a per-channel compare landing on the same tick while the mask selects that bit. With free random compare values, such a coincidence is practically never hit. The stimulus first loads the counter in special mode and then places compare values only a few counts ahead of the bench's own copy of the counter, so collisions between channels, and with channel 7, occur often. Directed sequences then force an exact override, a compare at the 0xFFFF-to-0x0000 wrap, and a counter load onto a compare value.

// File: rtl/oc_master_timer.sv
module oc_master_timer #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [PW-1:0] port_out
);
  localparam int IW    = $clog2(PW);
  localparam int ACTW  = 2 * (PW - 1);
  localparam int A_CNT = PW;
  localparam int A_ACT = PW + 1;
  localparam int A_MSK = PW + 2;
  localparam int A_DAT = PW + 3;

  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cmp [PW];
  logic [ACTW-1:0] act;
  logic [PW-1:0]   msk, dat, hit, pnext;

  wire            cnt_wr  = wr_en && addr == AW'(A_CNT) && !mode_n;
  wire            step    = tick && !cnt_wr;
  wire [CW-1:0]   cnt_nxt = cnt + 1'b1;

  function automatic logic apply_act(input logic cur, input logic [1:0] a);
    case (a)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  for (genvar n = 0; n < PW; n++) begin : g_ch
    assign hit[n] = step && cnt_nxt == cmp[n];
    if (n < PW - 1) begin : g_own
      assign pnext[n] = (hit[PW-1] && msk[n]) ? dat[n] :
                        hit[n] ? apply_act(port_out[n], act[2*n +: 2]) : port_out[n];
    end else begin : g_master
      assign pnext[n] = (hit[n] && msk[n]) ? dat[n] : port_out[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act      <= '0;
      msk      <= '0;
      dat      <= '0;
      port_out <= '0;
      for (int n = 0; n < PW; n++) cmp[n] <= '0;
    end else begin
      port_out <= pnext;
      if (cnt_wr)    cnt <= wdata;
      else if (tick) cnt <= cnt_nxt;
      if (wr_en) begin
        for (int n = 0; n < PW; n++)
          if (addr == AW'(n)) cmp[n] <= wdata;
        if (addr == AW'(A_ACT)) act <= wdata[ACTW-1:0];
        if (addr == AW'(A_MSK)) msk <= wdata[PW-1:0];
        if (addr == AW'(A_DAT)) dat <= wdata[PW-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < AW'(PW))          rdata = cmp[addr[IW-1:0]];
    else if (addr == AW'(A_CNT)) rdata = cnt;
    else if (addr == AW'(A_ACT)) rdata = CW'(act);
    else if (addr == AW'(A_MSK)) rdata = CW'(msk);
    else if (addr == AW'(A_DAT)) rdata = CW'(dat);
  end
endmodule

module oc_master_timer_chk #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          mode_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] wdata,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp7,
  input logic [PW-1:0] msk,
  input logic [PW-1:0] dat,
  input logic [PW-1:0] port_out
);
  wire ld = wr_en && addr == AW'(PW) && !mode_n;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld |=> cnt == CW'($past(cnt) + 1'b1));
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ld |=> $stable(cnt));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(wdata));
  // R4
  port_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(port_out));
  // R6
  master_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld && CW'(cnt + 1'b1) == cmp7 |=> ((port_out ^ $past(dat)) & $past(msk)) == '0);
endmodule

bind oc_master_timer oc_master_timer_chk #(.CW(CW), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_n(mode_n), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .cnt(cnt), .cmp7(cmp[PW-1]), .msk(msk),
  .dat(dat), .port_out(port_out)
);

// File: tb/test_oc_master_timer.sv
module test_oc_master_timer;
  localparam int TCLK = 10;

  logic        clk = 0, rst_n = 0, tick = 0, mode_n = 1, wr_en = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [7:0]  port_out;

  int checks = 0, fails = 0;

  logic [15:0] m_cnt, m_act;
  logic [15:0] m_cmp [8];
  logic [7:0]  m_msk, m_dat, m_port;

  oc_master_timer i_oc_master_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_n(mode_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .port_out(port_out)
  );

  always #(TCLK/2) clk = ~clk;

  initial begin
    #(TCLK * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic next_bit(input int n, input logic cur, input logic [7:0] hit);
    logic [1:0] a;
    if (hit[7] && m_msk[n]) return m_dat[n];
    if (n == 7 || !hit[n]) return cur;
    a = m_act[2*n +: 2];
    case (a)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic cyc(input logic w, input logic [3:0] a, input logic [15:0] d, input logic tk);
    logic       ld;
    logic [7:0] hit, np;
    wr_en = w; addr = a; wdata = d; tick = tk;
    @(posedge clk);
    ld = w && a == 4'd8 && !mode_n;
    for (int n = 0; n < 8; n++) hit[n] = tk && !ld && (m_cnt + 16'd1) == m_cmp[n];
    for (int n = 0; n < 8; n++) np[n] = next_bit(n, m_port[n], hit);
    m_port = np;
    if (w) begin
      if (a < 4'd8) m_cmp[a[2:0]] = d;
      if (a == 4'd9)  m_act = {2'b00, d[13:0]};
      if (a == 4'd10) m_msk = d[7:0];
      if (a == 4'd11) m_dat = d[7:0];
    end
    if (ld) m_cnt = d;
    else if (tk) m_cnt = m_cnt + 16'd1;
    @(negedge clk);
    wr_en = 0; tick = 0;
    chk("R4 R5 R6 R7 R8 port", {8'h00, port_out}, {8'h00, m_port});
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
    addr = a; wr_en = 0; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c07));
    m_cnt = 0; m_act = 0; m_msk = 0; m_dat = 0; m_port = 0;
    for (int n = 0; n < 8; n++) m_cmp[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk("R10 port", {8'h00, port_out}, 16'h0000);
    for (int a = 0; a < 12; a++) rd("R10 reg", 4'(a), 16'h0000);
    rd("R9 unused addr", 4'd13, 16'h0000);

    // R7 R8 override: ch2 and ch3 set, master clears bit3 only
    mode_n = 0;
    cyc(1, 4'd8, 16'h0100, 0);
    cyc(1, 4'd2, 16'h0102, 0);
    cyc(1, 4'd3, 16'h0102, 0);
    cyc(1, 4'd7, 16'h0102, 0);
    cyc(1, 4'd9, 16'h00F0, 0);
    cyc(1, 4'd10, 16'h0008, 0);
    cyc(1, 4'd11, 16'h0000, 0);
    rd("R9 mask readback", 4'd10, 16'h0008);
    cyc(0, 0, 0, 1);
    chk("R4 no match early", {8'h00, port_out}, 16'h0000);
    cyc(0, 0, 0, 1);
    chk("R7 override bit3, R5 set bit2", {8'h00, port_out}, 16'h0004);

    // R1 wrap and compare at 0x0000, R5 toggle
    cyc(1, 4'd0, 16'h0000, 0);
    cyc(1, 4'd9, 16'h0001, 0);
    cyc(1, 4'd8, 16'hFFFE, 0);
    cyc(0, 0, 0, 1);
    rd("R1 count", 4'd8, 16'hFFFF);
    cyc(0, 0, 0, 1);
    rd("R1 wrap", 4'd8, 16'h0000);
    chk("R5 toggle on wrap", {8'h00, port_out}, 16'h0005);

    // R2 write ignored in normal mode
    mode_n = 1;
    cyc(1, 4'd8, 16'h1234, 0);
    rd("R2 ignored write", 4'd8, 16'h0000);
    cyc(1, 4'd8, 16'h1234, 1);
    rd("R2 ignored write counts", 4'd8, 16'h0001);

    // R3 load onto a compare value does not trigger it; load beats tick
    mode_n = 0;
    cyc(1, 4'd8, 16'h0000, 0);
    cyc(1, 4'd8, 16'hFFFF, 1);
    chk("R3 no compare on load", {8'h00, port_out}, 16'h0005);
    rd("R3 load beats tick", 4'd8, 16'hFFFF);

    // R6 R8 master sets bit7 and bit6 only
    cyc(1, 4'd7, 16'h0003, 0);
    cyc(1, 4'd10, 16'h00C0, 0);
    cyc(1, 4'd11, 16'h00FF, 0);
    cyc(1, 4'd9, 16'h0000, 0);
    repeat (4) cyc(0, 0, 0, 1);
    chk("R6 R8 master masked load", {8'h00, port_out}, 16'h00C5);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if ($urandom_range(0, 49) == 0) mode_n = ~mode_n;
      if (op < 55)      cyc(0, 0, 0, 1);
      else if (op < 62) cyc(0, 0, 0, 0);
      else if (op < 80) cyc(1, 4'($urandom_range(0, 7)), m_cnt + 16'($urandom_range(1, 6)), 1'($urandom));
      else if (op < 85) cyc(1, 4'd9, 16'($urandom), 1'($urandom));
      else if (op < 90) cyc(1, 4'd10, 16'($urandom), 1'($urandom));
      else if (op < 95) cyc(1, 4'd11, 16'($urandom), 1'($urandom));
      else              cyc(1, 4'd8, 16'($urandom), 1'($urandom));
      if (i % 8 == 0) begin
        rd("R1 R2 R3 counter", 4'd8, m_cnt);
        rd("R9 data readback", 4'd11, {8'h00, m_dat});
        rd("R9 action readback", 4'd9, m_act);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule